// File: doc/BRIEF.md
# Indirect Clock-Strap Configuration Port

This block is a slave on a device-control register bus. It puts a wide, sparse space of read-only clock-divider and strap words behind just two bus-visible registers. One is an address pointer: software writes it to pick an internal word, and can read it back. The other is a data window: reading it returns the word that the current pointer selects.

Only five pointer values map to non-zero words, and one word is shared by two of them. Every other pointer value reads as zero through the window. Writes to the window are accepted but change nothing.

The bus side is a plain synchronous interface with a register number, write data, and separate read and write strobes. A register number that is neither of the two registers is not claimed: the block gives no acknowledge and returns zero data. For a claimed access, the response comes out of a register one cycle after the strobe, together with a one-cycle acknowledge.

Top module: `cfg_indirect_port`

## Requirements
- R1: After reset the pointer is zero, `ack` is low and `rd_data` is zero; reading the pointer register (register number 0x0C) returns 0.
- R2: A write to register number 0x0C loads all 32 bits of `wr_data` into the pointer; a later read of 0x0C returns that value unchanged.
- R3: A read of the data window (register number 0x0D) with pointer 0x0000_0060 returns 0xB501_0900 (0xB5 in bits 31:24, 1 in bits 23:16, 9 in bits 15:8).
- R4: A data-window read returns 0x0500_0000 with pointer 0x0000_0080 and 0x0200_0000 with pointer 0x0000_00C0.
- R5: A data-window read returns 0x0100_0000 with pointer 0x0000_00E0 and with pointer 0x0000_0100.
- R6: A data-window read with any other pointer value returns zero; all 32 pointer bits take part in the match, so 0x0000_1060 reads as zero.
- R7: A write to the data window is acknowledged, returns zero data, and leaves the pointer and every later window read unchanged.
- R8: An access whose register number is neither 0x0C nor 0x0D gets no acknowledge, returns zero data, and does not change the pointer.
- R9: For a read or write strobe to 0x0C or 0x0D, `ack` is high for exactly the next cycle and `rd_data` carries the result in that cycle. `rd_data` is zero whenever `ack` is low. Back-to-back strobes each get their own acknowledge.
- R10: When read and write strobes to 0x0C come in the same cycle, the read returns the pointer value from before the write, and the pointer takes the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_num | input | 10 | Bus register number of the access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, zero unless acknowledging a read |
| ack | output | 1 | One-cycle acknowledge for a claimed access |

## Verification
The hardest case to reach from the ports is a read and a write to the pointer in the same cycle. The read must return the old pointer, and the next window read must use the new one. The stimulus drives both strobes together at several pointer values and follows with an immediate window read. The other hard cases are stores that must have no effect: data-window writes and writes to unclaimed register numbers. These cannot be seen directly, so the bench reads the pointer and the window straight after them and checks that nothing moved. Back-to-back strobes with no idle cycle check that every acknowledge lines up with its own request.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DATA_W      = 32;
  localparam int REGNUM_W    = 10;
  localparam int NUM_ENTRIES = 6;

  localparam logic [REGNUM_W-1:0] REG_PTR  = 10'h00C;
  localparam logic [REGNUM_W-1:0] REG_DATA = 10'h00D;

  typedef struct packed {
    logic [DATA_W-1:0] key;
    logic [DATA_W-1:0] val;
  } rom_entry_t;

  // Constant words selectable through the data window.
  function automatic rom_entry_t rom_entry(input int idx);
    rom_entry_t e;
    case (idx)
      0:       e = '{key: 32'h0000_0060, val: 32'hB501_0900};
      1:       e = '{key: 32'h0000_0080, val: 32'h0500_0000};
      2:       e = '{key: 32'h0000_00C0, val: 32'h0200_0000};
      3:       e = '{key: 32'h0000_00E0, val: 32'h0100_0000};
      4:       e = '{key: 32'h0000_0100, val: 32'h0100_0000};
      default: e = '{key: 32'hFFFF_FFFF, val: 32'h0000_0000};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_ptr_reg.sv
module cfg_ptr_reg
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] ptr_q
);
  logic [DATA_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_en) ptr_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/cfg_rom_decode.sv
module cfg_rom_decode
  import cfgport_pkg::*;
(
  input  logic [DATA_W-1:0] ptr,
  output logic [DATA_W-1:0] word
);
  logic [NUM_ENTRIES-1:0]   hit;
  logic [DATA_W-1:0]        masked [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    localparam rom_entry_t ENT = rom_entry(g);
    assign hit[g]    = (ptr == ENT.key);
    assign masked[g] = hit[g] ? ENT.val : '0;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) word = word | masked[i];
  end
endmodule

// File: rtl/cfg_rsp_reg.sv
module cfg_rsp_reg
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claimed,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack
);
  logic [DATA_W-1:0] data_d;
  logic              ack_d;

  always_comb begin
    ack_d  = claimed & (rd_en | wr_en);
    data_d = (claimed & rd_en) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ack     <= 1'b0;
    end else begin
      rd_data <= data_d;
      ack     <= ack_d;
    end
  end
endmodule

// File: rtl/cfg_indirect_port.sv
module cfg_indirect_port
  import cfgport_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REGNUM_W-1:0] reg_num,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic                ack
);
  logic              rst_sync_n;
  logic              sel_ptr;
  logic              sel_data;
  logic              claimed;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] rom_word;
  logic [DATA_W-1:0] rd_val;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel_ptr  = (reg_num == REG_PTR);
    sel_data = (reg_num == REG_DATA);
    claimed  = sel_ptr | sel_data;
    rd_val   = sel_ptr ? ptr_q : rom_word;
  end

  cfg_ptr_reg u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (wr_en & sel_ptr),
    .load_val (wr_data),
    .ptr_q    (ptr_q)
  );

  cfg_rom_decode u_rom (
    .ptr  (ptr_q),
    .word (rom_word)
  );

  cfg_rsp_reg u_rsp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .claimed (claimed),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .rd_val  (rd_val),
    .rd_data (rd_data),
    .ack     (ack)
  );
endmodule

// File: rtl/cfg_indirect_port_chk.sv
module cfg_indirect_port_chk
  import cfgport_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [REGNUM_W-1:0] reg_num,
  input logic                rd_en,
  input logic                wr_en,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   rd_data,
  input logic                ack,
  input logic [DATA_W-1:0]   ptr_q
);
  logic is_ptr, is_data;
  assign is_ptr  = (reg_num == REG_PTR);
  assign is_data = (reg_num == REG_DATA);

  assert_ack_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && (is_ptr || is_data)) |=> ack);

  assert_no_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !is_ptr && !is_data) |=> (!ack && rd_data == '0));

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rd_data == '0));

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ptr) |=> (ptr_q == $past(wr_data)));

  assert_old_ptr_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_ptr) |=> (rd_data == $past(ptr_q)));

  assert_window_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_ptr) |=> $stable(ptr_q));

  assert_pll_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_data && ptr_q == 32'h0000_0060) |=> (rd_data == 32'hB501_0900));
endmodule

bind cfg_indirect_port cfg_indirect_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .reg_num (reg_num),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .ack     (ack),
  .ptr_q   (ptr_q)
);

// File: tb/cfg_indirect_port_bench.sv
module cfg_indirect_port_bench;
  logic        clk;
  logic        rst_n;
  logic [9:0]  reg_num;
  logic        rd_en;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ack;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [31:0] exp_ptr;

  typedef struct {
    int          due;
    logic        ack;
    logic [31:0] data;
    string       tag;
  } item_t;
  item_t sbq[$];

  cfg_indirect_port u_cfg_indirect_port (
    .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ack(ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] window_word(input logic [31:0] p);
    case (p)
      32'h060: return 32'hB501_0900;               // R3
      32'h080: return 32'h0500_0000;               // R4
      32'h0C0: return 32'h0200_0000;               // R4
      32'h0E0, 32'h100: return 32'h0100_0000;      // R5
      default: return 32'h0;                       // R6
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one access per call, pushes expected response for next cycle.
  task automatic access(input string tag, input logic [9:0] rn, input logic rd,
                        input logic wr, input logic [31:0] wd);
    item_t it;
    @(negedge clk);
    reg_num = rn; rd_en = rd; wr_en = wr; wr_data = wd;
    it.due = cyc + 1;
    it.tag = tag;
    it.ack = (rn == 10'h00C || rn == 10'h00D) && (rd || wr);
    it.data = 32'h0;
    if (rd && rn == 10'h00C) it.data = exp_ptr;
    if (rd && rn == 10'h00D) it.data = window_word(exp_ptr);
    sbq.push_back(it);
    if (wr && rn == 10'h00C) exp_ptr = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_num = '0; rd_en = 0; wr_en = 0; wr_data = '0;
    end
  endtask

  // Monitor: compares every cycle, idle cycles must be quiet (R9).
  always @(negedge clk) begin
    if (rst_n) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        check({it.tag, " ack"}, {31'b0, ack}, {31'b0, it.ack});
        check({it.tag, " data"}, rd_data, it.data);
      end else if (sbq.size() == 0 || sbq[0].due > cyc) begin
        check("R9 idle quiet", {31'b0, ack} | rd_data, 32'h0);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_ptr = '0;
    rst_n = 0; reg_num = '0; rd_en = 0; wr_en = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset ack", {31'b0, ack}, 32'h0);
    check("R1 reset data", rd_data, 32'h0);
    rst_n = 1;
    idle(4);
    access("R1 ptr after reset", 10'h00C, 1, 0, 0);
    access("R6 window ptr zero", 10'h00D, 1, 0, 0);
    idle(1);
    access("R2 write ptr", 10'h00C, 0, 1, 32'h060);
    access("R2 readback", 10'h00C, 1, 0, 0);
    access("R3 pll word", 10'h00D, 1, 0, 0);
    access("R4 write 080", 10'h00C, 0, 1, 32'h080);
    access("R4 read 080", 10'h00D, 1, 0, 0);
    access("R4 write 0C0", 10'h00C, 0, 1, 32'h0C0);
    access("R4 read 0C0", 10'h00D, 1, 0, 0);
    access("R5 write 0E0", 10'h00C, 0, 1, 32'h0E0);
    access("R5 read 0E0", 10'h00D, 1, 0, 0);
    access("R5 write 100", 10'h00C, 0, 1, 32'h100);
    access("R5 read 100", 10'h00D, 1, 0, 0);
    idle(2);
    access("R6 write 1060", 10'h00C, 0, 1, 32'h1060);
    access("R6 read 1060", 10'h00D, 1, 0, 0);
    access("R6 write 0A0", 10'h00C, 0, 1, 32'h0A0);
    access("R6 read 0A0", 10'h00D, 1, 0, 0);
    access("R2 write all ones", 10'h00C, 0, 1, 32'hFFFF_FFFF);
    access("R2 readback ones", 10'h00C, 1, 0, 0);
    access("R6 read ones", 10'h00D, 1, 0, 0);
    idle(1);
    access("R7 set ptr", 10'h00C, 0, 1, 32'h080);
    access("R7 window write", 10'h00D, 0, 1, 32'h1234_5678);
    access("R7 ptr kept", 10'h00C, 1, 0, 0);
    access("R7 window kept", 10'h00D, 1, 0, 0);
    idle(1);
    access("R8 unclaimed read", 10'h00E, 1, 0, 0);
    access("R8 unclaimed write", 10'h00B, 0, 1, 32'h060);
    access("R8 unclaimed write hi", 10'h20C, 0, 1, 32'h0C0);
    access("R8 ptr unchanged", 10'h00C, 1, 0, 0);
    idle(1);
    access("R10 rd+wr ptr", 10'h00C, 1, 1, 32'h060);
    access("R10 window new ptr", 10'h00D, 1, 0, 0);
    access("R10 rd+wr ptr again", 10'h00C, 1, 1, 32'h0E0);
    access("R10 readback new", 10'h00C, 1, 0, 0);
    access("R9 back-to-back a", 10'h00D, 1, 0, 0);
    access("R9 back-to-back b", 10'h00D, 1, 0, 0);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule